// File: doc/BRIEF.md
# Bidirectional Parallel Port Data Register

This block holds the data register of an 8-bit parallel printer port, together with the small control register that steers it. A host writes and reads the registers over a simple single-cycle register bus. The block has 8 bidirectional port pins, brought out as separate output data, output enable and pin input signals, so that the pad ring can build the tristate buffers.

A static mode input selects one of two behaviours. In the legacy mode (mode input low) the port is output only: every write goes straight to the pins and a read returns the latched value. In the extended mode (mode input high) a direction bit in the control register decides two things. It decides whether the pins are driven from the latch. It also decides whether a read of the data register returns the latch or the synchronised pin levels. Writes always land in the latch, even while the port is turned around to input, so the pins can be preloaded before output is re-enabled.

The extended mode also has a status flag. It records that the sampled pin value changed while the port was receiving. A read of the data register clears it.

Top module: `pport_data_reg`

## Requirements
- R1: After a synchronous reset with rst_n low, the latch is 0x00, the direction bit is 0, the status flag is 0, pin_out is 0x00 and pin_oe is 1.
- R2: A write at bus address 0 (bus_addr=0, bus_wr=1) stores bus_wdata in the latch, and pin_out shows it from the clock edge that takes the write, in both modes.
- R3: With mode_ext low, pin_oe is always 1 and a read at address 0 returns the latch, whatever the direction bit holds.
- R4: With mode_ext high and the direction bit 0, pin_oe is 1 and a read at address 0 returns the latch.
- R5: With mode_ext high and the direction bit 1, pin_oe is 0 and a read at address 0 returns pin_in through a two-flop synchroniser: a pin change before edge k is readable after edge k+1.
- R6: With mode_ext high, writes made while the direction bit is 1 still update the latch, and clearing the direction bit drives the latest latched value from the edge that takes the control write.
- R7: Address 1 is the control register: bit 0 is the direction bit (1 = input), which can be read and written; bit 1 is the read-only status flag; bits 7..2 read as 0.
- R8: The status flag sets, at the edge where the synchroniser output changes, only while mode_ext is high and the direction bit is 1. A read at address 0 (bus_rd=1) clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ext | input | 1 | Static mode select: 0 legacy output-only, 1 extended bidirectional |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (used only for flag clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational on bus_addr |
| pin_in | input | 8 | Levels sampled from the port pins |
| pin_out | output | 8 | Value to drive onto the port pins |
| pin_oe | output | 1 | Pin output enable, 1 = drive |

## Verification
Register writes, direction changes and flag updates take effect at the edge that samples the strobe. pin_out, pin_oe and the control readback therefore change one edge after the bus cycle. bus_rdata is combinational on bus_addr over that registered state. A pin change is visible in the data readback only after the second edge, and the flag sets on that same second edge. The bench advances a behavioural model at each rising edge, with a two-entry queue standing in for the synchroniser. It compares every output 1 ns after the edge, while the inputs driven on the falling edge are still stable. The directed checks sample at exactly these due edges.

// File: rtl/pport_pkg.sv
// Package: shared constants for the parallel port data register.
// Assumes a one-bit register address: data at 0, control at 1.
package pport_pkg;
    localparam int unsigned DATA_W        = 8;
    localparam int unsigned SYNC_STAGES   = 2;
    localparam logic        REG_DATA      = 1'b0;
    localparam logic        REG_CTRL      = 1'b1;
    localparam int unsigned CTRL_DIR_BIT  = 0;
    localparam int unsigned CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/pport_sync.sv
// Module: multi-stage synchroniser for the pin inputs.
// Provides the synchronised value and a change indicator. The indicator
// means "the output will change at the next edge".
// Assumes STAGES >= 2; synchronous active-low reset clears every stage.
module pport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         change
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    // The output stage differs from its feeder: it changes next edge.
    always_comb begin
        dout   = stg[STAGES-1];
        change = (stg[STAGES-1] != stg[STAGES-2]);
    end
endmodule

// File: rtl/pport_ctrl.sv
// Module: direction bit and receive-change status flag.
// The flag sets only in extended mode with the direction set to input.
// A data read clears it, and set wins over clear.
// Assumes mode_ext is static between resets.
module pport_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ext,
    input  logic wr_ctrl,
    input  logic wdir,
    input  logic rd_data,
    input  logic pin_change,
    output logic dir_q,
    output logic flag_q
);
    // Direction bit: written through the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= 1'b0;
        else if (wr_ctrl) dir_q <= wdir;
    end

    // Status flag: set on a sampled pin change in input mode, clear on data read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag_q <= 1'b0;
        else if (mode_ext && dir_q && pin_change)  flag_q <= 1'b1;
        else if (rd_data)                          flag_q <= 1'b0;
    end
endmodule

// File: rtl/pport_data_reg.sv
// Module: data register of an 8-bit parallel port with legacy and extended modes.
// Holds the output latch, drives the pin enable from mode and direction,
// and selects the readback source.
// Assumes single-cycle bus strobes and a static mode input.
module pport_data_reg
    import pport_pkg::*;
#(
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ext,
    input  logic          bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic          pin_oe
);
    localparam int unsigned PAD_W = DW - 2;

    logic [DW-1:0] latch_q;
    logic [DW-1:0] pin_sync;
    logic          pin_change;
    logic          dir_q;
    logic          flag_q;
    logic          wr_data, wr_ctrl, rd_data, recv;

    // Decode the bus strobes per register.
    always_comb begin
        wr_data = bus_wr && (bus_addr == REG_DATA);
        wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
        rd_data = bus_rd && (bus_addr == REG_DATA);
        recv    = mode_ext && dir_q;
    end

    // Output latch: every data write lands here, in any mode or direction.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (wr_data) latch_q <= bus_wdata;
    end

    pport_sync #(.W(DW), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .dout   (pin_sync),
        .change (pin_change)
    );

    pport_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ext   (mode_ext),
        .wr_ctrl    (wr_ctrl),
        .wdir       (bus_wdata[CTRL_DIR_BIT]),
        .rd_data    (rd_data),
        .pin_change (pin_change),
        .dir_q      (dir_q),
        .flag_q     (flag_q)
    );

    // Pin drive: the latch always feeds the pins; enable drops only when receiving.
    always_comb begin
        pin_out = latch_q;
        pin_oe  = !recv;
    end

    // Readback select: control word, or latch versus synchronised pins.
    always_comb begin
        if (bus_addr == REG_CTRL) begin
            bus_rdata = {{PAD_W{1'b0}}, flag_q, dir_q};
        end else if (recv) begin
            bus_rdata = pin_sync;
        end else begin
            bus_rdata = latch_q;
        end
    end
endmodule

// File: rtl/pport_chk.sv
// Module: assertion checker for pport_data_reg, attached by bind.
// Assumes mode_ext changes only while rst_n is low.
module pport_chk
    import pport_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_ext,
    input logic          bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] pin_out,
    input logic          pin_oe,
    input logic          dir_q,
    input logic          flag_q
);
    AST_RESET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe && pin_out == '0 && !dir_q && !flag_q)); // R1
    AST_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=> (pin_out == $past(bus_wdata))); // R2
    AST_COMPAT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ext |-> pin_oe); // R3
    AST_EXT_OUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ext && !dir_q && bus_addr == REG_DATA) |-> (bus_rdata == pin_out)); // R4
    AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ext && bus_wr && bus_addr == REG_CTRL) |=> (pin_oe == !$past(bus_wdata[CTRL_DIR_BIT]))); // R6
    AST_CTRL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTRL) |-> (bus_rdata[DW-1:2] == '0)); // R7
    AST_FLAG_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ext && !flag_q) |=> !flag_q); // R8
endmodule

bind pport_data_reg pport_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ext  (mode_ext),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .flag_q    (flag_q)
);

// File: tb/pport_data_reg_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model advanced at each rising edge and
// compared 1 ns later. Inputs are driven on the falling edge.
module pport_data_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ext = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic       pin_oe;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    // reference model state
    logic [7:0] m_latch;
    logic       m_dir, m_flag;
    logic [7:0] m_q[$];   // synchroniser queue, [0] newest, [1] output

    always #2 clk = ~clk;   // 250 MHz

    pport_data_reg u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the model from the pre-edge inputs and state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = '0; m_dir = 1'b0; m_flag = 1'b0;
            m_q = '{8'h00, 8'h00};
        end else begin
            logic chg;
            chg = (m_q[0] != m_q[1]);
            if (mode_ext && m_dir && chg)         m_flag = 1'b1;
            else if (bus_rd && bus_addr == 1'b0)  m_flag = 1'b0;
            if (bus_wr && bus_addr == 1'b1)       m_dir = bus_wdata[0];
            if (bus_wr && bus_addr == 1'b0)       m_latch = bus_wdata;
            m_q.push_front(pin_in);
            void'(m_q.pop_back());
        end
    end

    // Compare all outputs with the model 1 ns after each edge.
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            logic [7:0] exp_rd;
            logic       rcv;
            rcv = mode_ext && m_dir;
            chk("R2 pin_out", pin_out, m_latch);
            if (!mode_ext) chk("R3 pin_oe", {7'd0, pin_oe}, 8'd1);
            else if (!m_dir) chk("R4 pin_oe", {7'd0, pin_oe}, 8'd1);
            else chk("R5 pin_oe", {7'd0, pin_oe}, 8'd0);
            if (bus_addr) begin
                exp_rd = {6'd0, m_flag, m_dir};
                chk("R7 R8 ctrl read", bus_rdata, exp_rd);
            end else begin
                exp_rd = rcv ? m_q[1] : m_latch;
                if (!mode_ext) chk("R3 data read", bus_rdata, exp_rd);
                else if (!m_dir) chk("R4 data read", bus_rdata, exp_rd);
                else chk("R5 data read", bus_rdata, exp_rd);
            end
        end
    end

    // One bus cycle, driven on the falling edge.
    task automatic cyc(input logic wr, input logic rd, input logic a,
                       input logic [7:0] d, input logic [7:0] p);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; pin_in = p;
    endtask

    // Wait to 1 ns after the next rising edge (directed sampling point).
    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_ext = m; bus_wr = 0; bus_rd = 0; bus_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // ---- legacy mode
        do_reset(1'b0);
        after_edge();
        cmp_on = 1'b1;
        chk("R1 reset pin_out", pin_out, 8'h00);
        chk("R1 reset pin_oe", {7'd0, pin_oe}, 8'd1);
        bus_addr = 1'b1; #0.1;
        chk("R1 reset ctrl", bus_rdata, 8'h00);
        cyc(1, 0, 0, 8'hA5, 8'h11);
        after_edge();
        chk("R2 write shows at once", pin_out, 8'hA5);
        cyc(1, 0, 1, 8'h01, 8'h22);      // direction bit set, must not matter
        cyc(1, 0, 0, 8'h3C, 8'h33);
        cyc(0, 1, 0, 8'h00, 8'h44);
        after_edge();
        chk("R3 legacy ignores dir oe", {7'd0, pin_oe}, 8'd1);
        chk("R3 legacy read latch", bus_rdata, 8'h3C);
        for (int i = 0; i < 20; i++) cyc(i[0], !i[0], i[1], 8'(i * 37), 8'(i * 91));

        // ---- extended mode
        do_reset(1'b1);
        cyc(1, 0, 0, 8'h5A, 8'hC3);
        cyc(0, 1, 0, 8'h00, 8'hC3);
        after_edge();
        chk("R4 ext out read latch", bus_rdata, 8'h5A);
        cyc(1, 0, 1, 8'h01, 8'hC3);      // turn around to input
        after_edge();
        chk("R5 oe off", {7'd0, pin_oe}, 8'd0);
        cyc(0, 0, 0, 8'h00, 8'h96);      // pins change before edge k
        after_edge();                    // edge k
        chk("R5 not yet visible", bus_rdata, 8'hC3);
        after_edge();                    // edge k+1
        chk("R5 pins visible", bus_rdata, 8'h96);
        bus_addr = 1'b1; #0.1;
        chk("R8 flag set", bus_rdata, 8'h03);
        cyc(0, 1, 0, 8'h00, 8'h96);      // data read clears flag
        cyc(0, 0, 1, 8'h00, 8'h96);
        after_edge();
        chk("R8 flag cleared", bus_rdata, 8'h01);
        cyc(1, 0, 0, 8'h0F, 8'h96);      // write while receiving
        cyc(0, 0, 0, 8'h00, 8'h96);
        after_edge();
        chk("R6 read still pins", bus_rdata, 8'h96);
        cyc(1, 0, 1, 8'h00, 8'h96);      // back to output
        after_edge();
        chk("R6 latched value driven", pin_out, 8'h0F);
        chk("R6 oe back on", {7'd0, pin_oe}, 8'd1);
        cyc(0, 0, 0, 8'h00, 8'h55);
        repeat (4) cyc(0, 0, 1, 8'h00, 8'h55);
        after_edge();
        chk("R8 no set while driving", bus_rdata, 8'h00);

        // ---- mixed traffic against the model
        for (int i = 0; i < 400; i++)
            cyc(($urandom % 3) == 0, ($urandom % 4) == 0, 1'($urandom),
                8'($urandom), ((i % 5) == 0) ? 8'($urandom) : pin_in);
        do_reset(1'b0);
        for (int i = 0; i < 200; i++)
            cyc(($urandom % 3) == 0, ($urandom % 4) == 0, 1'($urandom),
                8'($urandom), 8'($urandom));
        after_edge();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule